// File: doc/BRIEF.md
# Slice Redundancy Mode Classifier

This block decides, for every slice of a reconfigurable logic array, whether that slice runs with triple redundancy. Each slice has three values in a local slice store: a normalized activity (power) figure, a failure likelihood and the index of the net it sits on. A small table holds one delay figure per net, and every slice on that net uses it. Two programmable limits split the power scale into three bands. A low-band slice drops redundancy. A high-band slice keeps it. For a middle-band slice the block computes a weighted score for "protected" and for "unprotected" and keeps the cheaper one.

A single-cycle `start` pulse begins a periodic pass. The pass walks the slice store in address order, which is raster order: the row index sits in the upper address bits and the column index in the lower bits. It handles one slice per clock. A slice is only re-decided when its power figure differs from the figure stored at its last decision. Every slice is decided on the first pass after reset. The per-slice enable bits come out as a vector that drives the clock gate and the power gate of each slice. The band tag and the enable of any single slice can be read back by address.

The sequencer has three named states:
- ST_IDLE waits for `start`.
- ST_SCAN evaluates one slice per cycle.
- ST_DONE lasts one cycle and raises `done`.

The transitions are:
- IDLE→SCAN on `start` with a valid configuration.
- SCAN→SCAN while slices remain.
- SCAN→DONE after the last slice.
- SCAN→IDLE as an abort when the configuration turns invalid during a pass.
- DONE→IDLE unconditionally.

Top module: `slc_redund_ctl`

## Requirements
- R1: `cfg_error` is high one clock after the configuration becomes invalid. The configuration is invalid when `w_fail + w_cost` differs from 256 (1.0) or when `thr_lo >= thr_hi`. While it is high, `start` is ignored: no pass runs, `busy` and `done` stay low, and no stored decision changes.
- R2: A re-decided slice whose power is strictly below `thr_lo` gets band code 1 and enable 0.
- R3: A re-decided slice whose power is strictly above `thr_hi` gets band code 2 and enable 1.
- R4: A re-decided slice whose power lies between `thr_lo` and `thr_hi`, both limits included, gets band code 3. Its enable comes from the score comparison.
- R5: All values are unsigned fractions with 256 meaning 1.0. The delay is the entry in the net delay table for the slice's net. The two scores are:
  - unprotected = `w_fail`·F + `w_cost`·PD
  - protected = `w_fail`·⌊F·`fail_scale`/256⌋ + `w_cost`·3·PD

  Here F is the failure figure and PD = ⌊power·delay/256⌋. The enable is 1 when the protected score is the lower one. With `w_fail` = 256 only the failure term counts.
- R6: When the two scores are equal, the enable is 1.
- R7: In a pass, a slice whose power equals the value stored at its last decision keeps its band code and enable, even if its failure figure changed. A slice whose power changed is re-decided.
- R8: A pass handles one slice per clock in address order. `busy` is high during the pass. `done` is high for exactly one cycle, and it rises NUM_SLICES clocks after the clock edge that accepted `start`.
- R9: After reset, every band code reads 0, every enable reads 0 and `slice_en` is all zero. `rd_region`/`rd_enable` and `slice_en` show the stored decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one pass |
| thr_lo | input | 8 | Lower band limit |
| thr_hi | input | 8 | Upper band limit |
| w_fail | input | 9 | Weight of the failure term (256 = 1.0) |
| w_cost | input | 9 | Weight of the power-delay term |
| fail_scale | input | 8 | Failure reduction ratio under redundancy |
| ld_en | input | 1 | Write one slice entry |
| ld_addr | input | 8 | Slice address (row, column) |
| ld_power | input | 8 | Normalized power |
| ld_fail | input | 8 | Failure likelihood |
| ld_net | input | 3 | Net index of the slice |
| nd_en | input | 1 | Write one net delay |
| nd_idx | input | 3 | Net index |
| nd_delay | input | 8 | Net delay |
| rd_addr | input | 8 | Readback address |
| rd_region | output | 2 | Band code: 0 undecided, 1 low, 2 high, 3 middle |
| rd_enable | output | 1 | Redundancy enable of the addressed slice |
| slice_en | output | 256 | Per-slice clock and power gate enable |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| cfg_error | output | 1 | Invalid weights or limits |

## Verification
The assertions assume a few things about how the block is driven:
- `start` is only pulsed while the block is idle.
- Configuration inputs are held steady during a pass, so the abort path is never taken.
- Slice and net-delay writes happen only between passes, so a pass reads a stable store.

The stimulus follows these rules. It loads the whole store before the first pass. It changes configuration only after `done`. It waits two clocks after any configuration change before pulsing `start`, so that `cfg_error` has settled. The invalid-configuration checks use the same idle-only stimulus, so the freeze is observed at the ports.

// File: rtl/slc_pkg.sv
package slc_pkg;
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_LOW  = 2'd1,
        REG_HIGH = 2'd2,
        REG_MID  = 2'd3
    } region_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_st_t;
endpackage

// File: rtl/slc_band.sv
module slc_band
    import slc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] power,
    input  logic [DW-1:0] lim_lo,
    input  logic [DW-1:0] lim_hi,
    output region_t       band
);
    always_comb begin
        if (power < lim_lo)       band = REG_LOW;
        else if (power > lim_hi)  band = REG_HIGH;
        else                      band = REG_MID;
    end
endmodule

// File: rtl/slc_score.sv
module slc_score #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] fail,
    input  logic [DW-1:0] power,
    input  logic [DW-1:0] delay,
    input  logic [DW:0]   wt_fail,
    input  logic [DW:0]   wt_cost,
    input  logic [DW-1:0] scale,
    output logic          pick_prot
);
    localparam int SW = 2 * DW + 4;

    logic [DW-1:0] fail_red;
    logic [DW-1:0] pd;
    logic [SW-1:0] score_plain;
    logic [SW-1:0] score_prot;

    always_comb begin
        fail_red    = DW'((32'(fail) * 32'(scale)) >> DW);
        pd          = DW'((32'(power) * 32'(delay)) >> DW);
        score_plain = SW'(32'(wt_fail) * 32'(fail)) + SW'(32'(wt_cost) * 32'(pd));
        score_prot  = SW'(32'(wt_fail) * 32'(fail_red)) + SW'(32'(wt_cost) * 32'(pd) * 32'd3);
        pick_prot   = (score_prot <= score_plain);
    end
endmodule

// File: rtl/slc_table.sv
module slc_table #(
    parameter int N  = 256,
    parameter int DW = 8,
    parameter int NB = 3,
    localparam int IW = $clog2(N),
    localparam int ND = 1 << NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_addr,
    input  logic [DW-1:0] ld_power,
    input  logic [DW-1:0] ld_fail,
    input  logic [NB-1:0] ld_net,
    input  logic          nd_en,
    input  logic [NB-1:0] nd_idx,
    input  logic [DW-1:0] nd_delay,
    input  logic [IW-1:0] sc_addr,
    output logic [DW-1:0] sc_power,
    output logic [DW-1:0] sc_fail,
    output logic [DW-1:0] sc_delay,
    output logic          sc_changed,
    input  logic          up_en,
    input  logic [1:0]    up_region,
    input  logic          up_enable,
    input  logic [IW-1:0] rd_addr,
    output logic [1:0]    rd_region,
    output logic          rd_enable,
    output logic [N-1:0]  en_vec
);
    logic [DW-1:0] pw_m   [N];
    logic [DW-1:0] pf_m   [N];
    logic [NB-1:0] nt_m   [N];
    logic [DW-1:0] last_m [N];
    logic [DW-1:0] dly_m  [ND];
    logic [1:0]    reg_m  [N];
    logic [N-1:0]  seen;
    logic [N-1:0]  en_v;

    always_ff @(posedge clk) begin
        if (ld_en) begin
            pw_m[ld_addr] <= ld_power;
            pf_m[ld_addr] <= ld_fail;
            nt_m[ld_addr] <= ld_net;
        end
        if (nd_en) dly_m[nd_idx] <= nd_delay;
        if (up_en) last_m[sc_addr] <= pw_m[sc_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
            en_v <= '0;
            for (int i = 0; i < N; i++) reg_m[i] <= 2'd0;
        end else if (up_en) begin
            seen[sc_addr]  <= 1'b1;
            en_v[sc_addr]  <= up_enable;
            reg_m[sc_addr] <= up_region;
        end
    end

    always_comb begin
        sc_power   = pw_m[sc_addr];
        sc_fail    = pf_m[sc_addr];
        sc_delay   = dly_m[nt_m[sc_addr]];
        sc_changed = !seen[sc_addr] || (last_m[sc_addr] != pw_m[sc_addr]);
        rd_region  = reg_m[rd_addr];
        rd_enable  = en_v[rd_addr];
        en_vec     = en_v;
    end
endmodule

// File: rtl/slc_redund_ctl.sv
module slc_redund_ctl
    import slc_pkg::*;
#(
    parameter int NUM_SLICES = 256,
    parameter int DW         = 8,
    parameter int NET_BITS   = 3,
    localparam int IW = $clog2(NUM_SLICES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DW-1:0]         thr_lo,
    input  logic [DW-1:0]         thr_hi,
    input  logic [DW:0]           w_fail,
    input  logic [DW:0]           w_cost,
    input  logic [DW-1:0]         fail_scale,
    input  logic                  ld_en,
    input  logic [IW-1:0]         ld_addr,
    input  logic [DW-1:0]         ld_power,
    input  logic [DW-1:0]         ld_fail,
    input  logic [NET_BITS-1:0]   ld_net,
    input  logic                  nd_en,
    input  logic [NET_BITS-1:0]   nd_idx,
    input  logic [DW-1:0]         nd_delay,
    input  logic [IW-1:0]         rd_addr,
    output logic [1:0]            rd_region,
    output logic                  rd_enable,
    output logic [NUM_SLICES-1:0] slice_en,
    output logic                  busy,
    output logic                  done,
    output logic                  cfg_error
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_SLICES - 1);
    localparam logic [DW+1:0] ONE_W    = (DW+2)'(1 << DW);

    scan_st_t      state, state_nx;
    logic [IW-1:0] idx;
    logic          cfg_q;
    logic          eval;
    logic [DW-1:0] sc_power, sc_fail, sc_delay;
    logic          sc_changed;
    region_t       band;
    logic          pick_prot;
    logic          up_en, up_enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= 1'b0;
        else cfg_q <= (({1'b0, w_fail} + {1'b0, w_cost}) != ONE_W) || (thr_lo >= thr_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SCAN) idx <= idx + 1'b1;
            else                  idx <= '0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start && !cfg_q) state_nx = ST_SCAN;
            ST_SCAN: begin
                if (cfg_q)                 state_nx = ST_IDLE;
                else if (idx == LAST_IDX)  state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state == ST_SCAN);
        done      = (state == ST_DONE);
        cfg_error = cfg_q;
        eval      = (state == ST_SCAN) && !cfg_q;
        up_en     = eval && sc_changed;
        unique case (band)
            REG_LOW:  up_enable = 1'b0;
            REG_HIGH: up_enable = 1'b1;
            default:  up_enable = pick_prot;
        endcase
    end

    slc_band #(.DW(DW)) u_band (
        .power (sc_power),
        .lim_lo(thr_lo),
        .lim_hi(thr_hi),
        .band  (band)
    );

    slc_score #(.DW(DW)) u_score (
        .fail     (sc_fail),
        .power    (sc_power),
        .delay    (sc_delay),
        .wt_fail  (w_fail),
        .wt_cost  (w_cost),
        .scale    (fail_scale),
        .pick_prot(pick_prot)
    );

    slc_table #(.N(NUM_SLICES), .DW(DW), .NB(NET_BITS)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_power  (ld_power),
        .ld_fail   (ld_fail),
        .ld_net    (ld_net),
        .nd_en     (nd_en),
        .nd_idx    (nd_idx),
        .nd_delay  (nd_delay),
        .sc_addr   (idx),
        .sc_power  (sc_power),
        .sc_fail   (sc_fail),
        .sc_delay  (sc_delay),
        .sc_changed(sc_changed),
        .up_en     (up_en),
        .up_region (band),
        .up_enable (up_enable),
        .rd_addr   (rd_addr),
        .rd_region (rd_region),
        .rd_enable (rd_enable),
        .en_vec    (slice_en)
    );

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_q && idx != LAST_IDX) |=> (busy && idx == $past(idx) + 1'b1));
    assert_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q && !busy) |=> (!busy && !done));
    assert_low_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && sc_power < thr_lo) |-> !up_enable);
    assert_high_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && sc_power > thr_hi) |-> up_enable);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(slice_en));
endmodule

// File: tb/sim_slc_redund_ctl.sv
module sim_slc_redund_ctl;
    localparam int N = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] thr_lo = 8'd64, thr_hi = 8'd192;
    logic [8:0] w_fail = 9'd128, w_cost = 9'd128;
    logic [7:0] fail_scale = 8'd64;
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = '0, ld_power = '0, ld_fail = '0;
    logic [2:0] ld_net = '0;
    logic       nd_en = 1'b0;
    logic [2:0] nd_idx = '0;
    logic [7:0] nd_delay = '0;
    logic [7:0] rd_addr = '0;
    logic [1:0] rd_region;
    logic       rd_enable;
    logic [N-1:0] slice_en;
    logic       busy, done, cfg_error;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] dly_ref [8];

    typedef struct {
        int         addr;
        logic [1:0] region;
        logic       en;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    slc_redund_ctl u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic ref_prot(input int f, input int p, input int d);
        int fr, pd, plain, prot;
        fr    = (f * fail_scale) >> 8;
        pd    = (p * d) >> 8;
        plain = w_fail * f + w_cost * pd;
        prot  = w_fail * fr + w_cost * 3 * pd;
        return prot <= plain;
    endfunction

    task automatic load(input int a, input int p, input int f, input int n);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 8'(a); ld_power = 8'(p); ld_fail = 8'(f); ld_net = 3'(n);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic set_delay(input int n, input int d);
        @(negedge clk);
        nd_en = 1'b1; nd_idx = 3'(n); nd_delay = 8'(d); dly_ref[n] = 8'(d);
        @(negedge clk);
        nd_en = 1'b0;
    endtask

    // driver: push an expected decision for a middle-band slice or a fixed band
    task automatic expect_mid(input int a, input int p, input int f, input int n, input string req);
        exp_t e;
        e.addr = a; e.region = 2'd3; e.en = ref_prot(f, p, dly_ref[n]); e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic expect_fix(input int a, input logic [1:0] r, input logic en, input string req);
        exp_t e;
        e.addr = a; e.region = r; e.en = en; e.req = req;
        sb_q.push_back(e);
    endtask

    // monitor: pops expectations and compares against readback and slice_en
    task automatic drain();
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            @(negedge clk);
            rd_addr = 8'(e.addr);
            #1;
            check({e.req, " region"}, int'(rd_region), int'(e.region));
            check({e.req, " enable"}, int'(rd_enable), int'(e.en));
            check({e.req, " slice_en"}, int'(slice_en[e.addr]), int'(e.en));
        end
    endtask

    task automatic run_pass(output int cycles);
        cycles = 0;
        @(negedge clk); @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
        @(negedge clk);
        check("R8 done width", int'(done), 0);
    endtask

    initial begin
        int cyc;
        int tmo;
        logic seen_busy;
        #1;
        check("R9 reset slice_en", int'(slice_en != '0), 0);
        check("R9 reset region", int'(rd_region), 0);
        check("R8 reset done", int'(done), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 8; n++) set_delay(n, 0);
        set_delay(1, 255);
        set_delay(2, 128);
        for (int a = 0; a < N; a++) load(a, 0, 0, 0);
        load(0, 63, 0, 0);
        load(1, 64, 0, 0);
        load(2, 192, 10, 1);
        load(3, 193, 0, 0);
        load(4, 100, 200, 2);

        run_pass(cyc);
        check("R8 pass length", cyc, N);
        expect_fix(0, 2'd1, 1'b0, "R2 below low limit");
        expect_fix(1, 2'd3, 1'b1, "R6 tie at low limit");
        expect_mid(2, 192, 10, 1, "R4 at high limit");
        expect_fix(2, 2'd3, 1'b0, "R5 cost term wins");
        expect_fix(3, 2'd2, 1'b1, "R3 above high limit");
        expect_mid(4, 100, 200, 2, "R5 weighted score");
        expect_fix(4, 2'd3, 1'b1, "R5 failure term wins");
        expect_fix(9, 2'd1, 1'b0, "R2 idle slice");
        drain();

        // R7: failure figure change alone is ignored; power change re-decides
        load(4, 100, 0, 2);
        load(2, 150, 255, 2);
        run_pass(cyc);
        expect_fix(4, 2'd3, 1'b1, "R7 unchanged power kept");
        expect_mid(2, 150, 255, 2, "R7 changed power");
        expect_fix(2, 2'd3, 1'b1, "R7 re-decided");
        drain();

        // R5: full weight on failure term
        w_fail = 9'd256; w_cost = 9'd0;
        load(7, 180, 4, 1);
        run_pass(cyc);
        check("R1 valid full weight", int'(cfg_error), 0);
        expect_fix(7, 2'd3, 1'b1, "R5 failure only");
        drain();

        // R1: bad weight sum freezes
        w_fail = 9'd100; w_cost = 9'd100;
        load(3, 10, 0, 0);
        @(negedge clk); @(negedge clk);
        check("R1 weight error flag", int'(cfg_error), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen_busy = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (busy || done) seen_busy = 1'b1;
        end
        check("R1 start ignored", int'(seen_busy), 0);
        expect_fix(3, 2'd2, 1'b1, "R1 no table change");
        drain();

        // R1: inverted limits
        w_fail = 9'd128; w_cost = 9'd128;
        thr_lo = 8'd200; thr_hi = 8'd100;
        @(negedge clk); @(negedge clk);
        check("R1 limit error flag", int'(cfg_error), 1);
        thr_lo = 8'd64; thr_hi = 8'd192;
        @(negedge clk); @(negedge clk);
        check("R1 error clears", int'(cfg_error), 0);
        run_pass(cyc);
        expect_fix(3, 2'd1, 1'b0, "R2 re-decided low");
        drain();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule